// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit register file and a 32-bit memory data bus. It takes one access at a time. Each access has a size (byte, word or longword), an address, store data and a read/write select. On a store, it steers the register bytes onto the bus lanes that the address selects and raises the matching byte enables. On a load, it gathers the addressed bytes from the read bus and sign-extends the result to a full 32-bit register value.

The byte order of word and longword accesses follows an endian-mode input. Addresses inside a fixed on-chip register window always use big endian order, whatever that input says. A word address that is not even, or a longword address that is not a multiple of four, is flagged as an address error. In that case no byte enable is raised. The whole block is combinational: every output belongs to the cycle of the request that produced it.

Top module: `lsu_align`

## Requirements
- R1: A byte access (size code 00) uses bus lane `addr[1:0]` in either byte order. Lane n occupies bus bits `8n+7:8n`. On a store, `storeData[7:0]` appears on that lane, and exactly that one byte-enable bit (bit n for lane n) is set.
- R2: A word store (size code 01) at an even address occupies lanes a and a+1, where a = `addr[1:0]`. Little endian puts `storeData[7:0]` on lane a. Big endian puts `storeData[15:8]` on lane a. The two matching enable bits are set.
- R3: A longword store (size code 10) at a multiple-of-four address sets all four enables. Big endian puts `storeData[31:24]` on lane 0 and `storeData[7:0]` on lane 3. Little endian puts `storeData[7:0]` on lane 0.
- R4: A byte load returns the addressed lane in `loadData[7:0]`, with bit 7 copied into `loadData[31:8]`.
- R5: A word load assembles its two lanes in the active byte order. Big endian takes the high byte from the lower address. Bit 15 is copied into `loadData[31:16]`.
- R6: A longword load assembles all four lanes in the active byte order. Big endian takes bits 31:24 from lane 0.
- R7: `addrErr` is 1 for a word access with `addr[0]`=1, for a longword access with `addr[1:0]`≠0, and for size code 11. It is 0 otherwise.
- R8: While `addrErr` is 1, `busByteEn` is 0 and `busWdata` is 0.
- R9: When `(addr & REGION_MASK) == REGION_BASE`, the access uses big endian order even with `bigEndian`=0.
- R10: With `isWrite`=0, `busByteEn` is 0. Bus lanes outside the access always carry 0 on `busWdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accSize | input | 2 | Access size: 00 byte, 01 word, 10 longword, 11 reserved |
| accAddr | input | 32 | Byte address of the access |
| storeData | input | 32 | Register value to store |
| isWrite | input | 1 | 1 store, 0 load |
| bigEndian | input | 1 | 1 big endian, 0 little endian (outside the register window) |
| busRdata | input | 32 | Read data from the memory bus, lane n at bits 8n+7:8n |
| busWdata | output | 32 | Lane-aligned store data |
| busByteEn | output | 4 | Per-lane write enables |
| loadData | output | 32 | Sign-extended load result |
| addrErr | output | 1 | Misaligned or reserved-size access |

## Verification
On every cycle, the assertions check three things: an error never leaves a byte enable set, a read never raises an enable, and the number of enables always matches the access size. They also check that byte and word load results are properly sign-extended. The assertions cannot show which lane each byte lands on, or that the register window really overrides the endian input. Only the bench's sweep shows these. The sweep covers every size, address offset, endian mode and direction, against a byte-addressed memory model.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int LOW_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic             bigOrder;   // effective byte order
    logic [LOW_W-1:0] firstLane;  // lowest lane touched
    logic [LOW_W-1:0] lastIdx;    // access size in bytes minus one
    logic [LANES-1:0] laneMask;   // lanes touched, zero on error
  } alignCtrl_t;
endpackage

// File: rtl/lsu_align_ctrl.sv
module lsu_align_ctrl
  import lsu_align_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] REGION_BASE = 32'hA400_0000,
  parameter logic [31:0] REGION_MASK = 32'hFF00_0000
) (
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              isWrite,
  input  logic              bigEndian,
  output alignCtrl_t        ctrl,
  output logic [LANES-1:0]  byteEn,
  output logic              addrErr
);
  logic [LOW_W-1:0] lowBits;
  logic [LANES-1:0] span;
  logic             inRegion;
  logic             misAlign;

  assign lowBits  = accAddr[LOW_W-1:0];
  assign inRegion = ((accAddr & REGION_MASK[ADDR_W-1:0]) == REGION_BASE[ADDR_W-1:0]);

  always_comb begin
    unique case (accSize_e'(accSize))
      SZ_BYTE: begin span = LANES'(1);       misAlign = 1'b0;           end
      SZ_WORD: begin span = LANES'(3);       misAlign = lowBits[0];     end
      SZ_LONG: begin span = {LANES{1'b1}};   misAlign = (lowBits != '0); end
      default: begin span = {LANES{1'b1}};   misAlign = 1'b1;           end
    endcase
  end

  always_comb begin
    ctrl.bigOrder  = bigEndian | inRegion;
    ctrl.firstLane = lowBits;
    ctrl.lastIdx   = (accSize == SZ_BYTE) ? LOW_W'(0) :
                     (accSize == SZ_WORD) ? LOW_W'(1) : LOW_W'(LANES - 1);
    ctrl.laneMask  = misAlign ? '0 : (span << lowBits);
  end

  assign addrErr = misAlign;
  assign byteEn  = isWrite ? ctrl.laneMask : '0;

  always_comb begin
    if (!$isunknown({accSize, lowBits, isWrite})) begin
      p_err_blocks_en_r8: assert (!(addrErr && (byteEn != '0)))
        else $error("R8: enables raised on address error");
      p_read_no_en_r10: assert (isWrite || (byteEn == '0))
        else $error("R10: enables raised on a read");
      p_en_count_r1: assert ((byteEn == '0) ||
                             ($countones(byteEn) == (32'(ctrl.lastIdx) + 1)))
        else $error("R1: enable count does not match access size");
    end
  end
endmodule

// File: rtl/lsu_align_dp.sv
module lsu_align_dp
  import lsu_align_pkg::*;
(
  input  alignCtrl_t        ctrl,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] loadData
);
  logic [BYTE_W-1:0] picked [LANES];
  logic              signBit;

  // Store path: each bus lane selects the register byte it carries.
  for (genvar L = 0; L < LANES; L++) begin : g_store
    logic [LOW_W-1:0] offs;
    logic [LOW_W-1:0] srcIdx;
    assign offs   = LOW_W'(L) - ctrl.firstLane;
    assign srcIdx = ctrl.bigOrder ? (ctrl.lastIdx - offs) : offs;
    assign busWdata[L*BYTE_W +: BYTE_W] =
      ctrl.laneMask[L] ? storeData[BYTE_W*srcIdx +: BYTE_W] : '0;
  end

  // Load path: each register byte selects the bus lane it comes from.
  for (genvar K = 0; K < LANES; K++) begin : g_load
    logic [LOW_W-1:0] srcLane;
    assign srcLane   = ctrl.bigOrder ? (ctrl.firstLane + ctrl.lastIdx - LOW_W'(K))
                                     : (ctrl.firstLane + LOW_W'(K));
    assign picked[K] = busRdata[BYTE_W*srcLane +: BYTE_W];
  end

  assign signBit = picked[ctrl.lastIdx][BYTE_W-1];

  for (genvar K = 0; K < LANES; K++) begin : g_ext
    assign loadData[K*BYTE_W +: BYTE_W] =
      (LOW_W'(K) <= ctrl.lastIdx) ? picked[K] : {BYTE_W{signBit}};
  end

  always_comb begin
    if (!$isunknown({ctrl, loadData})) begin
      if (ctrl.lastIdx == LOW_W'(0))
        p_byte_sext_r4: assert (loadData[DATA_W-1:BYTE_W] ==
                                {(DATA_W-BYTE_W){loadData[BYTE_W-1]}})
          else $error("R4: byte load not sign-extended");
      if (ctrl.lastIdx == LOW_W'(1))
        p_word_sext_r5: assert (loadData[DATA_W-1:2*BYTE_W] ==
                                {(DATA_W-2*BYTE_W){loadData[2*BYTE_W-1]}})
          else $error("R5: word load not sign-extended");
    end
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter logic [31:0] REGION_BASE = 32'hA400_0000,
  parameter logic [31:0] REGION_MASK = 32'hFF00_0000
) (
  input  logic [1:0]  accSize,
  input  logic [31:0] accAddr,
  input  logic [31:0] storeData,
  input  logic        isWrite,
  input  logic        bigEndian,
  input  logic [31:0] busRdata,
  output logic [31:0] busWdata,
  output logic [3:0]  busByteEn,
  output logic [31:0] loadData,
  output logic        addrErr
);
  alignCtrl_t ctrlStrobes;

  lsu_align_ctrl #(
    .ADDR_W      (32),
    .REGION_BASE (REGION_BASE),
    .REGION_MASK (REGION_MASK)
  ) u_ctrl (
    .accSize   (accSize),
    .accAddr   (accAddr),
    .isWrite   (isWrite),
    .bigEndian (bigEndian),
    .ctrl      (ctrlStrobes),
    .byteEn    (busByteEn),
    .addrErr   (addrErr)
  );

  lsu_align_dp u_dp (
    .ctrl      (ctrlStrobes),
    .storeData (storeData),
    .busRdata  (busRdata),
    .busWdata  (busWdata),
    .loadData  (loadData)
  );
endmodule

// File: tb/sim_lsu_align.sv
module sim_lsu_align;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RBASE      = 32'hA400_0000;
  localparam logic [31:0] RMASK      = 32'hFF00_0000;

  logic        clk = 1'b0;
  logic [1:0]  accSize   = '0;
  logic [31:0] accAddr   = '0;
  logic [31:0] storeData = '0;
  logic        isWrite   = 1'b0;
  logic        bigEndian = 1'b0;
  logic [31:0] busRdata  = '0;
  logic [31:0] busWdata;
  logic [3:0]  busByteEn;
  logic [31:0] loadData;
  logic        addrErr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_align #(.REGION_BASE(RBASE), .REGION_MASK(RMASK)) u0 (
    .accSize, .accAddr, .storeData, .isWrite, .bigEndian, .busRdata,
    .busWdata, .busByteEn, .loadData, .addrErr
  );

  // Behavioural model: register bytes placed into a byte-addressed window.
  task automatic refModel(input logic [1:0] sz, input logic [31:0] adr,
                          input logic [31:0] wd, input logic [31:0] rd,
                          input logic wr, input logic be,
                          output logic [31:0] ew, output logic [3:0] eben,
                          output logic [31:0] eld, output logic eerr);
    int  n;
    int  a;
    bit  big;
    logic s;
    n    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    a    = int'(adr[1:0]);
    big  = be || ((adr & RMASK) == RBASE);
    eerr = (sz == 2'd3) || (sz == 2'd1 && adr[0]) || (sz == 2'd2 && a != 0);
    ew = '0; eben = '0; eld = '0;
    if (!eerr) begin
      for (int k = 0; k < n; k++) begin
        int lane;
        lane = a + (big ? (n - 1 - k) : k);
        ew[lane*8 +: 8] = wd[k*8 +: 8];
        if (wr) eben[lane] = 1'b1;
        eld[k*8 +: 8] = rd[lane*8 +: 8];
      end
      if (n < 4) begin
        s = eld[n*8-1];
        for (int k = n; k < 4; k++) eld[k*8 +: 8] = {8{s}};
      end
    end
  endtask

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h (size %0d addr %h be %0b wr %0b)",
               tag, what, act, exp, accSize, accAddr, bigEndian, isWrite);
    end
  endtask

  task automatic drive(input logic [1:0] sz, input logic [31:0] adr,
                       input logic [31:0] wd, input logic [31:0] rd,
                       input logic wr, input logic be);
    @(posedge clk);
    #1;
    accSize = sz; accAddr = adr; storeData = wd; busRdata = rd;
    isWrite = wr; bigEndian = be;
    @(negedge clk);
  endtask

  task automatic stepCheck(input logic [1:0] sz, input logic [31:0] adr,
                           input logic [31:0] wd, input logic [31:0] rd,
                           input logic wr, input logic be, input string force_tag);
    logic [31:0] ew, eld;
    logic [3:0]  eben;
    logic        eerr;
    string       stTag, ldTag, enTag;
    drive(sz, adr, wd, rd, wr, be);
    refModel(sz, adr, wd, rd, wr, be, ew, eben, eld, eerr);
    stTag = (sz == 2'd0) ? "R1" : (sz == 2'd1) ? "R2" : "R3";
    ldTag = (sz == 2'd0) ? "R4" : (sz == 2'd1) ? "R5" : "R6";
    enTag = eerr ? "R8" : (!wr ? "R10" : stTag);
    if (eerr) stTag = "R8";
    if (force_tag != "") begin stTag = force_tag; ldTag = force_tag; end
    check32("R7", "addrErr", {31'd0, addrErr}, {31'd0, eerr});
    check32(enTag, "busByteEn", {28'd0, busByteEn}, {28'd0, eben});
    check32(stTag, "busWdata", busWdata, ew);
    if (!eerr) check32(ldTag, "loadData", loadData, eld);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h8A7B_6C5D;
    pats[1] = 32'h0123_4567;
    pats[2] = 32'hF00F_80FF;
    pats[3] = 32'h7F80_01FE;

    // Reset-state check: idle byte read at address 0.
    drive(2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
    check32("R10", "idle busByteEn", {28'd0, busByteEn}, 32'd0);
    check32("R7", "idle addrErr", {31'd0, addrErr}, 32'd0);

    // Directed literal cases.
    drive(2'd2, 32'h0000_0100, 32'h1122_3344, 32'h0, 1'b1, 1'b1);
    check32("R3", "big long store", busWdata, 32'h4433_2211);
    check32("R3", "long enables", {28'd0, busByteEn}, 32'h0000_000F);
    drive(2'd2, 32'h0000_0100, 32'h1122_3344, 32'h0, 1'b1, 1'b0);
    check32("R3", "little long store", busWdata, 32'h1122_3344);
    drive(2'd1, 32'h0000_0002, 32'h0000_ABCD, 32'h0, 1'b1, 1'b1);
    check32("R2", "big word store lane2", busWdata, 32'hCDAB_0000);
    drive(2'd0, 32'h0000_0003, 32'h0000_0077, 32'h0, 1'b1, 1'b0);
    check32("R1", "byte store lane3", busWdata, 32'h7700_0000);
    check32("R1", "byte enable lane3", {28'd0, busByteEn}, 32'h8);
    drive(2'd1, 32'h0000_0000, 32'h0, 32'h5555_3412, 1'b0, 1'b1);
    check32("R5", "big word load", loadData, 32'h0000_1234);
    drive(2'd0, 32'h0000_0001, 32'h0, 32'h0000_9000, 1'b0, 1'b0);
    check32("R4", "byte load sign", loadData, 32'hFFFF_FF90);
    drive(2'd2, 32'h0000_0000, 32'h0, 32'h4433_2211, 1'b0, 1'b1);
    check32("R6", "big long load", loadData, 32'h1122_3344);
    drive(2'd3, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0);
    check32("R7", "reserved size", {31'd0, addrErr}, 32'd1);
    check32("R8", "reserved no enables", {28'd0, busByteEn}, 32'd0);
    drive(2'd2, RBASE | 32'h10, 32'h1122_3344, 32'h0, 1'b1, 1'b0);
    check32("R9", "window forces big", busWdata, 32'h4433_2211);

    // Sweep: every size, offset, order and direction, several data patterns.
    for (int sz = 0; sz < 4; sz++)
      for (int a = 0; a < 4; a++)
        for (int be = 0; be < 2; be++)
          for (int wr = 0; wr < 2; wr++)
            for (int p = 0; p < 4; p++)
              stepCheck(2'(sz), 32'h0000_1000 | 32'(a), pats[p], pats[3-p],
                        1'(wr), 1'(be), "");

    // Register window with little endian selected must still act big endian.
    for (int sz = 0; sz < 3; sz++)
      for (int a = 0; a < 4; a++)
        for (int wr = 0; wr < 2; wr++)
          stepCheck(2'(sz), RBASE | 32'h0000_0040 | 32'(a), $urandom, $urandom,
                    1'(wr), 1'b0, "R9");

    // Random traffic.
    for (int i = 0; i < 400; i++)
      stepCheck(2'($urandom_range(0, 3)),
                ($urandom_range(0, 3) == 0) ? (RBASE | 32'($urandom_range(0, 255))) : $urandom,
                $urandom, $urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule